// File: doc/BRIEF.md
# Increment/Decrement Flag Unit

This block works out the processor-status byte for the four counting instructions of an 8-bit processor core. These are the single-register increment (INR) and decrement (DCR) and the register-pair increment (INX) and decrement (DCX). A strobe `go` captures the operand, the operation code, the current flag byte and the mode select. One clock later the block presents the new register value and the new flag byte, and raises `done` for that cycle. The flag byte is always given in the form that a push of the status word stores, so the fixed bits are already in place.

Two compatibility modes are supported. In the older mode, bit 1 of the status byte is a constant 1. The pair instructions touch no flag at all, not even zero. In the newer mode, bit 1 carries a signed-overflow flag, and bit 5 carries a pair-wrap flag. The pair instructions then update these two bits and keep the other flags.

Control is a two-state machine. `ST_IDLE` waits for `go`. The transition *capture* (`go` high) moves to `ST_DONE`, where `done` is high. From `ST_DONE`, *repeat* (`go` high again) stays in `ST_DONE`, and *release* (`go` low) returns to `ST_IDLE`. The registered results hold their values until the next capture.

Top module: `incdec_flag_unit`

## Requirements
- R1: With `op`=0 (INR), `result[7:0]` is `opnd[7:0]`+1 modulo 256 and `result[15:8]` equals `opnd[15:8]`. In the flag byte, bit 7 (sign) is the result's bit 7, bit 6 (zero) is set when the low result byte is 0, bit 2 is set for even parity of the low result byte, and bit 0 (carry) is copied from `flags_in[0]`.
- R2: With `op`=1 (DCR), the result is formed the same way with `opnd[7:0]`-1 modulo 256. The sign, zero, parity and carry rules are those of R1.
- R3: Bit 4 (half carry) follows its own rule for each operation. For INR it is set exactly when the low nibble of the result is 0x0. For DCR it is set exactly when the low nibble of the result is not 0xF.
- R4: With `mode85`=0, every flag byte has bit 1 = 1, bit 5 = 0 and bit 3 = 0. In both modes bit 3 is always 0.
- R5: With `mode85`=0 and `op`=2 (INX) or `op`=3 (DCX), `result` is `opnd`±1 modulo 65536. The flag byte then carries bits 7, 6, 4, 2 and 0 unchanged from `flags_in`, even when the result is zero.
- R6: With `mode85`=1, bit 1 (V) after INR is set only for 0x7F to 0x80, and after DCR only for 0x80 to 0x7F; otherwise it is 0. For example, 0x16 to 0x15 leaves V clear. INR and DCR keep bit 5 from `flags_in`.
- R7: With `mode85`=1, bit 5 (UI) after INX is set only for 0xFFFF to 0x0000, and after DCX only for 0x0000 to 0xFFFF. Every other pair result clears it.
- R8: With `mode85`=1, V after INX is set only for 0x7FFF to 0x8000, and after DCX only for 0x8000 to 0x7FFF; otherwise it is 0. Bits 7, 6, 4, 2 and 0 are kept from `flags_in`. For example, INX of 0xFFFE with all-clear flags yields flag byte 0x00.
- R9: `done` is high in exactly the cycles that follow a clock edge at which `go` was high. `result` and `flags_out` change only on such an edge and otherwise hold their values.
- R10: While `rst_n` is low, `done` is 0, `result` is 0x0000 and `flags_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Capture strobe for the operation inputs |
| op | input | 2 | 0 INR, 1 DCR, 2 INX, 3 DCX |
| mode85 | input | 1 | 1 selects newer-mode flag rules, 0 older-mode rules |
| opnd | input | 16 | Operand; the low byte is used for INR/DCR |
| flags_in | input | 8 | Current status byte |
| done | output | 1 | Results valid this cycle |
| result | output | 16 | New register or pair value |
| flags_out | output | 8 | New status byte, in pushed form |

## Verification
Each result passes through a single register. `done`, `result` and `flags_out` are therefore due in the cycle that follows the rising edge at which `go` was sampled high. The bench changes its inputs at falling edges and raises `go` for one edge. It reads the outputs at the next falling edge, half a period after they settle. It then reads them again one falling edge later, when `done` must be low and both values must be unchanged. Back-to-back strobes are checked at each falling edge between them.

// File: rtl/incdec_pkg.sv
package incdec_pkg;
    localparam int BYTE_W = 8;
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int FLAG_W = 8;

    localparam int FB_SIGN  = 7;
    localparam int FB_ZERO  = 6;
    localparam int FB_WRAP  = 5;
    localparam int FB_HALF  = 4;
    localparam int FB_FIX3  = 3;
    localparam int FB_PAR   = 2;
    localparam int FB_OVF   = 1;
    localparam int FB_CARRY = 0;

    typedef enum logic [1:0] {
        OP_INR = 2'd0,
        OP_DCR = 2'd1,
        OP_INX = 2'd2,
        OP_DCX = 2'd3
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } st_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic wrap;
        logic half;
        logic par;
        logic ovf;
        logic carry;
    } flag_set_t;
endpackage

// File: rtl/incdec_byte_calc.sv
module incdec_byte_calc #(
    parameter int W = 8
) (
    input  logic         dec,
    input  logic [W-1:0] a,
    output logic [W-1:0] r,
    output logic         sign,
    output logic         zero,
    output logic         half,
    output logic         par,
    output logic         ovf
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        r    = dec ? (a - 1'b1) : (a + 1'b1);
        sign = r[W-1];
        zero = (r == '0);
        par  = ~^r;
        half = dec ? (r[3:0] != 4'hF) : (r[3:0] == 4'h0);
        ovf  = dec ? (a == MIN_NEG) : (a == MAX_POS);
    end
endmodule

// File: rtl/incdec_pair_calc.sv
module incdec_pair_calc #(
    parameter int W = 16
) (
    input  logic         dec,
    input  logic [W-1:0] a,
    output logic [W-1:0] r,
    output logic         wrap,
    output logic         ovf
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        r    = dec ? (a - 1'b1) : (a + 1'b1);
        wrap = dec ? (a == '0) : (a == '1);
        ovf  = dec ? (a == MIN_NEG) : (a == MAX_POS);
    end
endmodule

// File: rtl/incdec_flag_pack.sv
module incdec_flag_pack
    import incdec_pkg::*;
(
    input  logic              mode85,
    input  flag_set_t         f,
    output logic [FLAG_W-1:0] byte_out
);
    always_comb begin
        byte_out           = '0;
        byte_out[FB_SIGN]  = f.sign;
        byte_out[FB_ZERO]  = f.zero;
        byte_out[FB_HALF]  = f.half;
        byte_out[FB_PAR]   = f.par;
        byte_out[FB_CARRY] = f.carry;
        byte_out[FB_FIX3]  = 1'b0;
        if (mode85) begin
            byte_out[FB_WRAP] = f.wrap;
            byte_out[FB_OVF]  = f.ovf;
        end else begin
            byte_out[FB_WRAP] = 1'b0;
            byte_out[FB_OVF]  = 1'b1;
        end
    end
endmodule

// File: rtl/incdec_flag_unit.sv
module incdec_flag_unit
    import incdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [1:0]        op,
    input  logic              mode85,
    input  logic [PAIR_W-1:0] opnd,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              done,
    output logic [PAIR_W-1:0] result,
    output logic [FLAG_W-1:0] flags_out
);
    st_e state_q, state_d;

    logic              is_pair, is_dec;
    logic [BYTE_W-1:0] r8;
    logic              s8, z8, h8, p8, v8;
    logic [PAIR_W-1:0] r16;
    logic              wrap16, v16;
    flag_set_t         fnext;
    logic [PAIR_W-1:0] res_next;
    logic [FLAG_W-1:0] byte_next;

    assign is_pair = (op == OP_INX) || (op == OP_DCX);
    assign is_dec  = (op == OP_DCR) || (op == OP_DCX);

    incdec_byte_calc #(.W(BYTE_W)) u_byte (
        .dec(is_dec), .a(opnd[BYTE_W-1:0]), .r(r8),
        .sign(s8), .zero(z8), .half(h8), .par(p8), .ovf(v8)
    );

    incdec_pair_calc #(.W(PAIR_W)) u_pair (
        .dec(is_dec), .a(opnd), .r(r16), .wrap(wrap16), .ovf(v16)
    );

    always_comb begin
        fnext.sign  = flags_in[FB_SIGN];
        fnext.zero  = flags_in[FB_ZERO];
        fnext.half  = flags_in[FB_HALF];
        fnext.par   = flags_in[FB_PAR];
        fnext.carry = flags_in[FB_CARRY];
        fnext.wrap  = flags_in[FB_WRAP];
        fnext.ovf   = flags_in[FB_OVF];
        if (is_pair) begin
            res_next   = r16;
            fnext.wrap = wrap16;
            fnext.ovf  = v16;
        end else begin
            res_next   = {opnd[PAIR_W-1:BYTE_W], r8};
            fnext.sign = s8;
            fnext.zero = z8;
            fnext.half = h8;
            fnext.par  = p8;
            fnext.ovf  = v8;
        end
    end

    incdec_flag_pack u_pack (
        .mode85(mode85), .f(fnext), .byte_out(byte_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = go ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = go ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            flags_out <= '0;
        end else if (go) begin
            result    <= res_next;
            flags_out <= byte_next;
        end
    end

    assign done = (state_q == ST_DONE);

    // R1
    keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(op[1])) |-> (flags_out[FB_CARRY] == $past(flags_in[FB_CARRY])));

    // R4
    fixed_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(mode85)) |-> (flags_out[FB_OVF] && !flags_out[FB_WRAP]));

    // R4
    bit3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[FB_FIX3] == 1'b0);

    // R5
    old_pair_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(mode85) && $past(op[1])) |->
        ({flags_out[7:6], flags_out[4], flags_out[2], flags_out[0]} ==
         {$past(flags_in[7:6]), $past(flags_in[4]), $past(flags_in[2]), $past(flags_in[0])}));

    // R7
    pair_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mode85) && $past(op) == 2'd2 && $past(opnd) == '1) |->
        (flags_out[FB_WRAP] && result == '0));

    // R9
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> done);

    // R9
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(go));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ($stable(result) && $stable(flags_out)));
endmodule

// File: tb/tb_incdec_flag_unit.sv
module tb_incdec_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        mode85 = 1'b0;
    logic [15:0] opnd = 16'h0;
    logic [7:0]  flags_in = 8'h0;
    logic        done;
    logic [15:0] result;
    logic [7:0]  flags_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int cycles = 0;

    incdec_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .go(go), .op(op), .mode85(mode85),
        .opnd(opnd), .flags_in(flags_in), .done(done),
        .result(result), .flags_out(flags_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // {op, mode85, opnd, flags_in, expected result, expected flags}
    localparam int NV = 18;
    localparam logic [50:0] VEC [NV] = '{
        {2'd0, 1'b0, 16'h1234, 8'h00, 16'h1235, 8'h06}, // R1 R4
        {2'd0, 1'b0, 16'h00FF, 8'h01, 16'h0000, 8'h57}, // R1 R3 zero, carry kept
        {2'd1, 1'b0, 16'h0016, 8'h00, 16'h0015, 8'h12}, // R2 R3
        {2'd1, 1'b1, 16'h0016, 8'h00, 16'h0015, 8'h10}, // R6 no overflow
        {2'd0, 1'b1, 16'h007F, 8'h00, 16'h0080, 8'h92}, // R6 INR overflow
        {2'd1, 1'b1, 16'h0080, 8'h01, 16'h007F, 8'h03}, // R6 DCR overflow, R3 nibble F
        {2'd1, 1'b1, 16'h0000, 8'h20, 16'h00FF, 8'hA4}, // R6 UI kept
        {2'd1, 1'b0, 16'hAB01, 8'hFF, 16'hAB00, 8'h57}, // R2 R4 fixed bits
        {2'd2, 1'b0, 16'hFFFF, 8'h95, 16'h0000, 8'h97}, // R5 zero not set
        {2'd3, 1'b0, 16'h0000, 8'h2A, 16'hFFFF, 8'h02}, // R5 R4
        {2'd2, 1'b1, 16'hFFFE, 8'h00, 16'hFFFF, 8'h00}, // R8 R7 no wrap
        {2'd2, 1'b1, 16'hFFFF, 8'h00, 16'h0000, 8'h20}, // R7 INX wrap
        {2'd3, 1'b1, 16'h0000, 8'hC1, 16'hFFFF, 8'hE1}, // R7 DCX wrap
        {2'd2, 1'b1, 16'h7FFF, 8'h20, 16'h8000, 8'h02}, // R8 INX overflow
        {2'd3, 1'b1, 16'h8000, 8'h14, 16'h7FFF, 8'h16}, // R8 DCX overflow
        {2'd3, 1'b1, 16'h1235, 8'h22, 16'h1234, 8'h00}, // R7 R8 cleared
        {2'd0, 1'b0, 16'h000F, 8'h00, 16'h0010, 8'h12}, // R3 INR nibble 0
        {2'd0, 1'b1, 16'h00FF, 8'h00, 16'h0000, 8'h54}  // R1 R6 wrap to zero
    };

    task automatic issue(input logic [1:0] o, input logic m, input logic [15:0] a,
                         input logic [7:0] f);
        op = o; mode85 = m; opnd = a; flags_in = f; go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 done", {15'd0, done}, 16'd0);
        check("R10 result", result, 16'h0000);
        check("R10 flags", {8'd0, flags_out}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle done", {15'd0, done}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            logic [50:0] v;
            v = VEC[i];
            issue(v[50:49], v[48], v[47:32], v[31:24]);
            check($sformatf("R9 done row %0d", i), {15'd0, done}, 16'd1);
            check($sformatf("table row %0d result", i), result, v[23:8]);
            check($sformatf("table row %0d flags", i), {8'd0, flags_out}, {8'd0, v[7:0]});
            opnd = ~opnd; flags_in = ~flags_in;
            @(negedge clk);
            check($sformatf("R9 release row %0d", i), {15'd0, done}, 16'd0);
            check($sformatf("R9 hold row %0d", i), result, v[23:8]);
        end

        // R9 back-to-back strobes keep done high
        op = 2'd0; mode85 = 1'b1; opnd = 16'h0041; flags_in = 8'h00; go = 1'b1;
        @(negedge clk);
        check("R9 b2b first done", {15'd0, done}, 16'd1);
        check("R1 b2b first result", result, 16'h0042);
        op = 2'd1; opnd = 16'h0050;
        @(negedge clk);
        go = 1'b0;
        check("R9 b2b second done", {15'd0, done}, 16'd1);
        check("R2 b2b second result", result, 16'h004F);
        // 0x4F: low nibble F so half clear; five ones so parity clear
        check("R3 b2b second flags", {8'd0, flags_out}, 16'h0000);
        @(negedge clk);
        check("R9 b2b end", {15'd0, done}, 16'd0);

        // R10 reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 again result", result, 16'h0000);
        check("R10 again flags", {8'd0, flags_out}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule